// File: doc/BRIEF.md
# Timestamp Latency Calibration Sequencer

This block measures the transmit and receive path latency of a multirate Ethernet PHY and loads the resulting corrections into the timestamp correction registers of the MAC. It acts as a master on two simple register buses: a read-only bus toward the PHY and a write-only bus toward the MAC. A sequence starts on a `start` pulse, or on a `speed_chg` pulse after a dynamic link-speed change, because bit slips and FIFO fill levels alter the latency after every power-up and every speed change.

A sequence first polls the PHY status word until both path-valid bits are set, under a limit set at an input. It then reads eight 16-bit PHY words holding the 32-bit delay-line counts and soft-PCS delays. For each direction it scales the delay-line count by a per-speed factor, adds the soft-PCS delay, shifts the integer nanosecond sum into a 16.16 fixed-point value and adds the static PMA delay. The integer part and the upper fraction byte then go to separate MAC registers. When the poll limit runs out, the block reports an error and writes nothing to the MAC.

Top module: `lat_cal_seq`

## Requirements
- R1: After reset, `busy`, `done`, `error`, `phy_rd_en` and `mac_wr_en` are all low.
- R2: When the block is idle, a `start` or `speed_chg` pulse makes `busy` high on the next clock edge, and the first PHY read is at word address 0x17. That address is the byte address 0x5C shifted right by 2.
- R3: The status word at 0x17 is read repeatedly until a read returns bit 0 (TX valid) and bit 1 (RX valid) both set. A value with only one of the two bits set counts as not valid.
- R4: If `poll_limit` status reads in a row return not-valid, the sequence ends with `error` high, `done` low and `busy` low, and no MAC write is made. A `poll_limit` of 0 acts as 1.
- R5: After a valid status read, the block reads PHY words 0x18 to 0x1F once each, in ascending order. The pair {0x19,0x18} is the TX delay-line count, {0x1B,0x1A} the RX count, {0x1D,0x1C} the TX soft-PCS delay and {0x1F,0x1E} the RX soft-PCS delay. In each pair the odd address is the upper half.
- R6: The TX result is L = ((count × scale + pcs) mod 2^16) × 65536 + tx_pma, taken mod 2^32. The block writes {16'h0, L[31:16]} to MAC address 0xD60.
- R7: The fractional writes carry {16'h0, L[15:8], 8'h00}. The TX result goes to 0xD64 and the RX result to 0xD5C.
- R8: The RX result is formed as in R6 from the RX count, the RX soft-PCS delay and `rx_pma`. The block writes {16'h0, L[31:16]} to MAC address 0xD58.
- R9: The four MAC writes occur in the order 0xD60, 0xD64, 0xD58, 0xD5C. After the last one, `done` is high and `busy` is low. `done` and `error` are never high together.
- R10: The scale factor is picked by the `speed` value captured when the sequence starts: 0 selects 8, 1 selects 4, 2 selects 2 and 3 selects 1 (default parameter).
- R11: A `speed_chg` pulse that arrives during a sequence is held, and a new sequence begins right after the current one ends. A `start` pulse that arrives during a sequence has no effect.
- R12: A PHY read request or MAC write request stays asserted with a stable address until the bus acknowledges it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Start-calibration pulse |
| speed_chg | input | 1 | Link-speed-change pulse |
| speed | input | 2 | Link speed code, selects the scale factor |
| poll_limit | input | 16 | Maximum number of status reads |
| tx_pma | input | 32 | TX PMA delay, 16.16 ns |
| rx_pma | input | 32 | RX PMA delay, 16.16 ns |
| phy_rd_en | output | 1 | PHY read request |
| phy_addr | output | 8 | PHY word address |
| phy_rdata | input | 16 | PHY read data, valid with ack |
| phy_ack | input | 1 | PHY read acknowledge |
| mac_wr_en | output | 1 | MAC write request |
| mac_addr | output | 12 | MAC register byte address |
| mac_wdata | output | 32 | MAC write data |
| mac_ack | input | 1 | MAC write acknowledge |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | Last sequence finished with writes |
| error | output | 1 | Last sequence timed out |

## Verification
The hardest case to reach from the ports is a speed change that arrives in the middle of a running sequence. It must be held over without disturbing the running sequence, and the next sequence must then pick up the new speed code. The bench pulses `speed_chg` and `start` while the PHY model is still answering reads, changes `speed` at the same time, and then checks two things: the status word is read exactly twice, and the second group of four MAC writes uses the new scale. Polling-timeout and partial-valid cases are produced by a PHY model that returns a not-valid status word for a chosen number of reads. The hold rule is exercised by an acknowledge delay that the bench can set.

// File: rtl/lat_cal_pkg.sv
package lat_cal_pkg;

    localparam int PHY_AW   = 8;
    localparam int PHY_BW   = PHY_AW + 2;
    localparam int MAC_AW   = 12;
    localparam int REG_W    = 16;
    localparam int LAT_W    = 32;
    localparam int NUM_RD   = 8;
    localparam int RD_IW    = $clog2(NUM_RD);
    localparam int NUM_WR   = 4;
    localparam int WR_IW    = $clog2(NUM_WR);

    localparam logic [PHY_BW-1:0] BYTE_STATUS  = 10'h05C;
    localparam logic [PHY_BW-1:0] BYTE_DL_BASE = 10'h060;

    localparam logic [MAC_AW-1:0] MAC_TX_INT  = 12'hD60;
    localparam logic [MAC_AW-1:0] MAC_TX_FRAC = 12'hD64;
    localparam logic [MAC_AW-1:0] MAC_RX_INT  = 12'hD58;
    localparam logic [MAC_AW-1:0] MAC_RX_FRAC = 12'hD5C;

    typedef enum logic [1:0] {S_IDLE, S_POLL, S_READ, S_WRITE} seq_state_t;

    typedef struct packed {
        logic [LAT_W-1:0] count;
        logic [LAT_W-1:0] pcs;
    } path_meas_t;

    function automatic logic [PHY_AW-1:0] byte_to_word(input logic [PHY_BW-1:0] b);
        return b[PHY_BW-1:2];
    endfunction

    function automatic logic [LAT_W-1:0] int_word(input logic [LAT_W-1:0] lat);
        return {16'h0000, lat[31:16]};
    endfunction

    function automatic logic [LAT_W-1:0] frac_word(input logic [LAT_W-1:0] lat);
        return {16'h0000, lat[15:8], 8'h00};
    endfunction

endpackage

// File: rtl/lat_cal_math.sv
module lat_cal_math
    import lat_cal_pkg::*;
#(
    parameter int SCALE_W = 8
) (
    input  path_meas_t         meas,
    input  logic [SCALE_W-1:0] scale,
    input  logic [LAT_W-1:0]   pma,
    output logic [LAT_W-1:0]   lat
);
    localparam int PROD_W = LAT_W + SCALE_W;

    logic [PROD_W-1:0] prod;
    logic [15:0]       ns_sum;

    always_comb begin
        prod   = {{SCALE_W{1'b0}}, meas.count} * {{LAT_W{1'b0}}, scale};
        ns_sum = prod[15:0] + meas.pcs[15:0];
        lat    = {ns_sum, 16'h0000} + pma;
    end
endmodule

// File: rtl/lat_cal_fsm.sv
module lat_cal_fsm
    import lat_cal_pkg::*;
#(
    parameter int SPD_W = 2
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 start,
    input  logic                 speed_chg,
    input  logic [SPD_W-1:0]     speed,
    input  logic [15:0]          poll_limit,
    input  logic [LAT_W-1:0]     tx_lat,
    input  logic [LAT_W-1:0]     rx_lat,
    output logic                 phy_rd_en,
    output logic [PHY_AW-1:0]    phy_addr,
    input  logic [REG_W-1:0]     phy_rdata,
    input  logic                 phy_ack,
    output logic                 mac_wr_en,
    output logic [MAC_AW-1:0]    mac_addr,
    output logic [LAT_W-1:0]     mac_wdata,
    input  logic                 mac_ack,
    output logic                 busy,
    output logic                 done,
    output logic                 error,
    output logic [SPD_W-1:0]     speed_q,
    output path_meas_t           tx_meas,
    output path_meas_t           rx_meas
);
    seq_state_t                       state;
    logic                             pend;
    logic [15:0]                      poll_cnt;
    logic [RD_IW-1:0]                 rd_idx;
    logic [WR_IW-1:0]                 wr_idx;
    logic [NUM_RD-1:0][REG_W-1:0]     words;

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= S_IDLE;
            pend     <= 1'b0;
            done     <= 1'b0;
            error    <= 1'b0;
            poll_cnt <= '0;
            rd_idx   <= '0;
            wr_idx   <= '0;
            words    <= '0;
            speed_q  <= '0;
        end else begin
            if (speed_chg && state != S_IDLE)
                pend <= 1'b1;
            unique case (state)
                S_IDLE: begin
                    if (start || speed_chg || pend) begin
                        state    <= S_POLL;
                        pend     <= 1'b0;
                        done     <= 1'b0;
                        error    <= 1'b0;
                        poll_cnt <= '0;
                        speed_q  <= speed;
                    end
                end
                S_POLL: begin
                    if (phy_ack) begin
                        if (phy_rdata[1:0] == 2'b11) begin
                            state  <= S_READ;
                            rd_idx <= '0;
                        end else if ({1'b0, poll_cnt} + 17'd1 >= {1'b0, poll_limit}) begin
                            state <= S_IDLE;
                            error <= 1'b1;
                        end else begin
                            poll_cnt <= poll_cnt + 16'd1;
                        end
                    end
                end
                S_READ: begin
                    if (phy_ack) begin
                        words[rd_idx] <= phy_rdata;
                        if (rd_idx == RD_IW'(NUM_RD - 1)) begin
                            state  <= S_WRITE;
                            wr_idx <= '0;
                        end else begin
                            rd_idx <= rd_idx + 1'b1;
                        end
                    end
                end
                S_WRITE: begin
                    if (mac_ack) begin
                        if (wr_idx == WR_IW'(NUM_WR - 1)) begin
                            state <= S_IDLE;
                            done  <= 1'b1;
                        end else begin
                            wr_idx <= wr_idx + 1'b1;
                        end
                    end
                end
                default: state <= S_IDLE;
            endcase
        end
    end

    always_comb begin
        busy      = (state != S_IDLE);
        phy_rd_en = (state == S_POLL) || (state == S_READ);
        mac_wr_en = (state == S_WRITE);
        if (state == S_POLL)
            phy_addr = byte_to_word(BYTE_STATUS);
        else
            phy_addr = byte_to_word(BYTE_DL_BASE + {{(PHY_BW-RD_IW-2){1'b0}}, rd_idx, 2'b00});
        tx_meas.count = {words[1], words[0]};
        rx_meas.count = {words[3], words[2]};
        tx_meas.pcs   = {words[5], words[4]};
        rx_meas.pcs   = {words[7], words[6]};
        unique case (wr_idx)
            2'd0:    begin mac_addr = MAC_TX_INT;  mac_wdata = int_word(tx_lat);  end
            2'd1:    begin mac_addr = MAC_TX_FRAC; mac_wdata = frac_word(tx_lat); end
            2'd2:    begin mac_addr = MAC_RX_INT;  mac_wdata = int_word(rx_lat);  end
            default: begin mac_addr = MAC_RX_FRAC; mac_wdata = frac_word(rx_lat); end
        endcase
    end
endmodule

// File: rtl/lat_cal_seq.sv
module lat_cal_seq
    import lat_cal_pkg::*;
#(
    parameter int NUM_SPEEDS = 4,
    parameter int SCALE_W    = 8,
    parameter logic [NUM_SPEEDS-1:0][SCALE_W-1:0] SPEED_SCALE = {8'd1, 8'd2, 8'd4, 8'd8}
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         start,
    input  logic                         speed_chg,
    input  logic [$clog2(NUM_SPEEDS)-1:0] speed,
    input  logic [15:0]                  poll_limit,
    input  logic [LAT_W-1:0]             tx_pma,
    input  logic [LAT_W-1:0]             rx_pma,
    output logic                         phy_rd_en,
    output logic [PHY_AW-1:0]            phy_addr,
    input  logic [REG_W-1:0]             phy_rdata,
    input  logic                         phy_ack,
    output logic                         mac_wr_en,
    output logic [MAC_AW-1:0]            mac_addr,
    output logic [LAT_W-1:0]             mac_wdata,
    input  logic                         mac_ack,
    output logic                         busy,
    output logic                         done,
    output logic                         error
);
    localparam int SPD_W = $clog2(NUM_SPEEDS);

    logic [SPD_W-1:0]   speed_q;
    path_meas_t         meas [2];
    logic [LAT_W-1:0]   pma  [2];
    logic [LAT_W-1:0]   lat  [2];
    logic [SCALE_W-1:0] scale;

    assign scale  = SPEED_SCALE[speed_q];
    assign pma[0] = tx_pma;
    assign pma[1] = rx_pma;

    lat_cal_fsm #(.SPD_W(SPD_W)) u_fsm (
        .clk        (clk),
        .rst        (rst),
        .start      (start),
        .speed_chg  (speed_chg),
        .speed      (speed),
        .poll_limit (poll_limit),
        .tx_lat     (lat[0]),
        .rx_lat     (lat[1]),
        .phy_rd_en  (phy_rd_en),
        .phy_addr   (phy_addr),
        .phy_rdata  (phy_rdata),
        .phy_ack    (phy_ack),
        .mac_wr_en  (mac_wr_en),
        .mac_addr   (mac_addr),
        .mac_wdata  (mac_wdata),
        .mac_ack    (mac_ack),
        .busy       (busy),
        .done       (done),
        .error      (error),
        .speed_q    (speed_q),
        .tx_meas    (meas[0]),
        .rx_meas    (meas[1])
    );

    for (genvar p = 0; p < 2; p++) begin : g_path
        lat_cal_math #(.SCALE_W(SCALE_W)) u_math (
            .meas  (meas[p]),
            .scale (scale),
            .pma   (pma[p]),
            .lat   (lat[p])
        );
    end
endmodule

// File: rtl/lat_cal_seq_chk.sv
module lat_cal_seq_chk
    import lat_cal_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              busy,
    input logic              done,
    input logic              error,
    input logic              phy_rd_en,
    input logic [PHY_AW-1:0] phy_addr,
    input logic              phy_ack,
    input logic              mac_wr_en,
    input logic [MAC_AW-1:0] mac_addr,
    input logic [LAT_W-1:0]  mac_wdata,
    input logic              mac_ack
);
    AST_RESET_QUIET: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!busy && !done && !error && !phy_rd_en && !mac_wr_en)); // R1

    AST_BUS_ONLY_BUSY: assert property (@(posedge clk) disable iff (rst)
        (phy_rd_en || mac_wr_en) |-> busy); // R2

    AST_ERR_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
        error |-> !mac_wr_en); // R4

    AST_INT_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst)
        (mac_wr_en && (mac_addr == MAC_TX_INT || mac_addr == MAC_RX_INT)) |-> (mac_wdata[31:16] == 16'h0)); // R6

    AST_FRAC_SHAPE: assert property (@(posedge clk) disable iff (rst)
        (mac_wr_en && (mac_addr == MAC_TX_FRAC || mac_addr == MAC_RX_FRAC))
            |-> (mac_wdata[31:16] == 16'h0 && mac_wdata[7:0] == 8'h0)); // R7

    AST_DONE_XOR_ERR: assert property (@(posedge clk) disable iff (rst)
        !(done && error)); // R9

    AST_ONE_BUS: assert property (@(posedge clk) disable iff (rst)
        !(phy_rd_en && mac_wr_en)); // R9

    AST_PHY_HOLD: assert property (@(posedge clk) disable iff (rst)
        (phy_rd_en && !phy_ack) |=> (phy_rd_en && $stable(phy_addr))); // R12

    AST_MAC_HOLD: assert property (@(posedge clk) disable iff (rst)
        (mac_wr_en && !mac_ack) |=> (mac_wr_en && $stable(mac_addr) && $stable(mac_wdata))); // R12
endmodule

bind lat_cal_seq lat_cal_seq_chk u_chk (.*);

// File: tb/lat_cal_seq_test.sv
`timescale 1ns/1ps
module lat_cal_seq_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic        speed_chg = 1'b0;
    logic [1:0]  speed = 2'd0;
    logic [15:0] poll_limit = 16'd10;
    logic [31:0] tx_pma = 32'h0;
    logic [31:0] rx_pma = 32'h0;
    logic        phy_rd_en;
    logic [7:0]  phy_addr;
    logic [15:0] phy_rdata = 16'h0;
    logic        phy_ack = 1'b0;
    logic        mac_wr_en;
    logic [11:0] mac_addr;
    logic [31:0] mac_wdata;
    logic        mac_ack = 1'b0;
    logic        busy, done, error;

    always #2 clk = ~clk;

    lat_cal_seq uut (.*);

    // bus models
    logic [15:0] phy_mem [0:31];
    int          ack_dly = 0;
    int          pdcnt = 0, mdcnt = 0;
    int          fail_n = 0;
    logic [15:0] fail_val = 16'h0;
    int          stat_n = 0, stat_base = 0;
    logic [7:0]  rd_log [0:511];
    int          rd_n = 0;
    logic [11:0] wr_alog [0:255];
    logic [31:0] wr_dlog [0:255];
    int          wr_n = 0;
    int          checks = 0, errors = 0, cyc = 0;

    always @(posedge clk) begin
        if (rst) begin
            phy_ack <= 1'b0;
            mac_ack <= 1'b0;
            pdcnt   <= 0;
            mdcnt   <= 0;
        end else begin
            if (phy_rd_en && !phy_ack) begin
                if (pdcnt >= ack_dly) begin
                    phy_ack <= 1'b1;
                    pdcnt   <= 0;
                    if (phy_addr == 8'h17) begin
                        phy_rdata <= ((stat_n - stat_base) < fail_n) ? fail_val : 16'h0003;
                        stat_n    <= stat_n + 1;
                    end else begin
                        phy_rdata <= phy_mem[phy_addr[4:0]];
                    end
                    rd_log[rd_n[8:0]] <= phy_addr;
                    rd_n <= rd_n + 1;
                end else pdcnt <= pdcnt + 1;
            end else phy_ack <= 1'b0;
            if (mac_wr_en && !mac_ack) begin
                if (mdcnt >= ack_dly) begin
                    mac_ack <= 1'b1;
                    mdcnt   <= 0;
                    wr_alog[wr_n[7:0]] <= mac_addr;
                    wr_dlog[wr_n[7:0]] <= mac_wdata;
                    wr_n <= wr_n + 1;
                end else mdcnt <= mdcnt + 1;
            end else mac_ack <= 1'b0;
        end
    end

    task automatic report();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            errors = errors + 1;
            $display("FAIL watchdog: run hung, act=%0d cycles exp<=150000", cyc);
            report();
        end
    end

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: act=0x%0h exp=0x%0h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_lat(input logic [31:0] cnt, input logic [31:0] pcs,
                                            input int scale, input logic [31:0] pma);
        logic [63:0] t;
        t = 64'(cnt) * 64'(scale) + 64'(pcs);
        return 32'({t[15:0], 16'h0}) + pma;
    endfunction

    function automatic int scale_of(input logic [1:0] s);
        return 8 >> s;
    endfunction

    task automatic load_phy(input logic [31:0] tc, input logic [31:0] rc,
                            input logic [31:0] tp, input logic [31:0] rp);
        phy_mem[5'h18] = tc[15:0]; phy_mem[5'h19] = tc[31:16];
        phy_mem[5'h1A] = rc[15:0]; phy_mem[5'h1B] = rc[31:16];
        phy_mem[5'h1C] = tp[15:0]; phy_mem[5'h1D] = tp[31:16];
        phy_mem[5'h1E] = rp[15:0]; phy_mem[5'h1F] = rp[31:16];
    endtask

    // pulse a trigger, check R2 entry, then wait for the end
    task automatic trigger(input bit use_chg);
        @(negedge clk);
        stat_base = stat_n;
        if (use_chg) speed_chg = 1'b1; else start = 1'b1;
        @(negedge clk);
        speed_chg = 1'b0; start = 1'b0;
        check(busy === 1'b1, "R2 busy after trigger", 32'(busy), 1);
        check(phy_rd_en === 1'b1 && phy_addr === 8'h17, "R2 first read at 0x17", 32'(phy_addr), 32'h17);
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 3000 && busy; i++) @(negedge clk);
    endtask

    task automatic check_writes(input int base, input logic [31:0] txl, input logic [31:0] rxl, input string tag);
        check(wr_n - base == 4, {"R9 write count ", tag}, 32'(wr_n - base), 4);
        check(wr_alog[base[7:0]] == 12'hD60 && wr_dlog[base[7:0]] == {16'h0, txl[31:16]},
              {"R6 tx int ", tag}, wr_dlog[base[7:0]], {16'h0, txl[31:16]});
        check(wr_alog[8'(base+1)] == 12'hD64 && wr_dlog[8'(base+1)] == {16'h0, txl[15:8], 8'h0},
              {"R7 tx frac ", tag}, wr_dlog[8'(base+1)], {16'h0, txl[15:8], 8'h0});
        check(wr_alog[8'(base+2)] == 12'hD58 && wr_dlog[8'(base+2)] == {16'h0, rxl[31:16]},
              {"R8 rx int ", tag}, wr_dlog[8'(base+2)], {16'h0, rxl[31:16]});
        check(wr_alog[8'(base+3)] == 12'hD5C && wr_dlog[8'(base+3)] == {16'h0, rxl[15:8], 8'h0},
              {"R7 rx frac ", tag}, wr_dlog[8'(base+3)], {16'h0, rxl[15:8], 8'h0});
    endtask

    task automatic t_reset();
        check(!busy && !done && !error && !phy_rd_en && !mac_wr_en, "R1 reset state",
              {27'h0, busy, done, error, phy_rd_en, mac_wr_en}, 0);
    endtask

    task automatic t_basic();
        int rb = rd_n, wb = wr_n;
        bit seq_ok = 1;
        speed = 2'd0; ack_dly = 0; fail_n = 0; poll_limit = 16'd10;
        tx_pma = 32'h0012_3456; rx_pma = 32'h0001_80FF;
        load_phy(32'h10, 32'h20, 32'h5, 32'h7);
        trigger(0);
        wait_idle();
        check(done && !error && !busy, "R9 done after writes", {29'h0, done, error, busy}, 32'b100);
        check(rd_n - rb == 9, "R5 read count", 32'(rd_n - rb), 9);
        for (int i = 0; i < 9; i++)
            if (rd_log[9'(rb + i)] != 8'(8'h17 + i)) seq_ok = 0;
        check(seq_ok, "R5 read order 0x17..0x1F", 32'(rd_log[9'(rb + 1)]), 32'h18);
        check_writes(wb, 32'h0097_3456, 32'h0108_80FF, "basic");
    endtask

    task automatic t_poll_partial();
        int rb = rd_n, wb = wr_n;
        speed = 2'd0; ack_dly = 1; fail_n = 3; fail_val = 16'h0001; poll_limit = 16'd10;
        tx_pma = 32'h0; rx_pma = 32'h0;
        load_phy(32'h1, 32'h2, 32'h0, 32'h0);
        trigger(0);
        wait_idle();
        check(stat_n - stat_base == 4, "R3 status polled until both bits", 32'(stat_n - stat_base), 4);
        check(rd_log[9'(rb + 3)] == 8'h17 && rd_log[9'(rb + 4)] == 8'h18, "R3 only status during poll",
              32'(rd_log[9'(rb + 4)]), 32'h18);
        check_writes(wb, exp_lat(1, 0, 8, 0), exp_lat(2, 0, 8, 0), "poll");
    endtask

    task automatic t_timeout();
        int wb = wr_n;
        ack_dly = 0; fail_n = 1000; fail_val = 16'h0002; poll_limit = 16'd5;
        trigger(1);
        wait_idle();
        check(error && !done && !busy, "R4 timeout error", {29'h0, done, error, busy}, 32'b010);
        check(stat_n - stat_base == 5, "R4 status read count", 32'(stat_n - stat_base), 5);
        check(wr_n == wb, "R4 no MAC writes", 32'(wr_n - wb), 0);
        poll_limit = 16'd0;
        trigger(0);
        wait_idle();
        check(error && stat_n - stat_base == 1, "R4 zero limit acts as one", 32'(stat_n - stat_base), 1);
        fail_n = 0;
    endtask

    task automatic t_speeds();
        logic [31:0] tc = 32'h0001_0003, rc = 32'h0000_1234;
        logic [31:0] tp = 32'h0000_0101, rp = 32'h0002_00FF;
        for (int s = 1; s < 4; s++) begin
            int wb = wr_n;
            speed = 2'(s); ack_dly = 2; poll_limit = 16'd4;
            tx_pma = 32'h0000_FFFF; rx_pma = 32'hFFFF_8000;
            load_phy(tc, rc, tp, rp);
            trigger(0);
            speed = 2'd0;
            wait_idle();
            check_writes(wb, exp_lat(tc, tp, scale_of(2'(s)), 32'h0000_FFFF),
                         exp_lat(rc, rp, scale_of(2'(s)), 32'hFFFF_8000), $sformatf("R10 speed %0d", s));
        end
    endtask

    task automatic t_latched();
        int wb = wr_n, sb;
        ack_dly = 0; fail_n = 0; poll_limit = 16'd4; speed = 2'd0;
        tx_pma = 32'h0; rx_pma = 32'h0;
        load_phy(32'h9, 32'h11, 32'h1, 32'h2);
        trigger(0);
        sb = stat_base;
        repeat (5) @(negedge clk);
        speed = 2'd3;
        speed_chg = 1'b1; start = 1'b1;
        @(negedge clk);
        speed_chg = 1'b0; start = 1'b0;
        repeat (150) @(negedge clk);
        check(stat_n - sb == 2, "R11 held change gives one more sequence", 32'(stat_n - sb), 2);
        check(wr_n - wb == 8, "R11 eight writes", 32'(wr_n - wb), 8);
        check(wr_dlog[8'(wb + 0)] == {16'h0, exp_lat(9, 1, 8, 0) >> 16}, "R11 first uses old speed",
              wr_dlog[8'(wb + 0)], exp_lat(9, 1, 8, 0) >> 16);
        check(wr_dlog[8'(wb + 4)] == {16'h0, exp_lat(9, 1, 1, 0) >> 16}, "R11 second uses new speed",
              wr_dlog[8'(wb + 4)], exp_lat(9, 1, 1, 0) >> 16);
        check(done && !busy, "R11 finished", {30'h0, done, busy}, 32'b10);
        // start alone during busy is ignored
        wb = wr_n;
        trigger(0);
        sb = stat_base;
        repeat (4) @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (150) @(negedge clk);
        check(stat_n - sb == 1 && wr_n - wb == 4, "R11 start while busy ignored", 32'(wr_n - wb), 4);
    endtask

    initial begin
        for (int i = 0; i < 32; i++) phy_mem[i] = 16'h0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_basic();
        t_poll_partial();
        t_timeout();
        t_speeds();
        t_latched();
        report();
    end
endmodule